// File: doc/BRIEF.md
# Resumable NMI Trap Controller

This block chooses which trap a hart takes and where execution goes next. Resumable non-maskable interrupt (RNMI) sources, regular interrupts and synchronous exceptions arrive together. The block picks one winner, computes the target program counter and privilege mode, and raises a one-cycle strobe. It also owns a small set of NMI state registers: the NMI enable bit, the saved privilege and virtualization bits, the NMI cause and the NMI exception PC. An RNMI handler uses these to resume the interrupted context.

RNMIs rank above every regular interrupt. The NMI enable bit gates all asynchronous traps, and the bit is cleared on RNMI entry and after reset. A separate return input sets it again. While the bit is clear, a synchronous exception that targets machine mode jumps to a fixed RNMI exception vector instead of the regular machine trap vector. Other traps take the usual delegation decision and the direct or vectored target computation.

Top module: `rnmi_trap_ctrl`

## Requirements
- R1: After synchronous reset, `trap_taken` is 0, `nmi_en` is 0, `next_priv` is 3 (machine), and `nmi_cause`, `nmi_epc` and `next_pc` are 0.
- R2: While `nmi_en` is 0, no RNMI and no regular interrupt is taken, whatever `rnmi_pend`, `irq_req` and `boundary` are.
- R3: A taken RNMI wins over a regular interrupt and over a synchronous exception presented in the same cycle. A regular interrupt that is taken wins over an exception.
- R4: With several RNMI sources pending, the taken source is the lowest set bit index of `rnmi_pend`. `nmi_cause` becomes that index with bit XLEN-1 set.
- R5: On RNMI entry, in the same clock edge: `nmi_en` clears, `nmi_prev_priv` takes `cur_priv`, `nmi_prev_virt` takes `cur_virt`, `nmi_epc` takes `cur_pc`, `next_pc` becomes the RNMI interrupt vector and `next_priv` becomes 3.
- R6: A regular trap goes to supervisor mode (`next_priv` = 1) only when `cur_priv` is 0 (user) or 1 (supervisor), the cause is below XLEN, and `deleg[cause]` is 1. Its PC is then computed from `stvec` by the rule of R8.
- R7: A synchronous exception routed to machine mode while `nmi_en` is 0 sets `next_pc` to the RNMI exception vector.
- R8: For any other regular trap, the base is the trap-vector register with its low two bits cleared. The trap PC is the base plus cause×4 when the trap is an interrupt and the register's bits [1:0] equal 1. Otherwise the trap PC is the base.
- R9: RNMIs and regular interrupts are accepted only in cycles with `boundary` = 1. Exceptions are accepted in any cycle.
- R10: `trap_taken` is high for exactly the one cycle after each clock edge that accepts a trap. `next_pc` and `next_priv` hold their values between traps.
- R11: `nmi_ret` = 1 sets `nmi_en` to 1 at the next edge unless an RNMI is accepted at that edge.
- R12: Regular interrupts and exceptions leave `nmi_en`, `nmi_cause`, `nmi_epc`, `nmi_prev_priv` and `nmi_prev_virt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary | input | 1 | Current cycle is an instruction boundary |
| rnmi_pend | input | NSRC | Pending RNMI sources |
| irq_req | input | 1 | A regular (already enabled) interrupt is pending |
| irq_cause | input | 8 | Cause number of the regular interrupt |
| exc_req | input | 1 | Synchronous exception request |
| exc_cause | input | 8 | Exception cause number |
| cur_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| cur_virt | input | 1 | Current virtualization bit |
| cur_pc | input | XLEN | Current program counter |
| deleg | input | XLEN | Delegation mask, one bit per cause |
| mtvec | input | XLEN | Machine trap-vector register |
| stvec | input | XLEN | Supervisor trap-vector register |
| nmi_ret | input | 1 | NMI return: re-enable NMI |
| trap_taken | output | 1 | One-cycle strobe per accepted trap |
| next_pc | output | XLEN | Target PC of the last trap |
| next_priv | output | 2 | Target privilege of the last trap |
| nmi_en | output | 1 | NMI enable bit |
| nmi_prev_priv | output | 2 | Privilege saved on RNMI entry |
| nmi_prev_virt | output | 1 | Virtualization bit saved on RNMI entry |
| nmi_cause | output | XLEN | NMI cause register |
| nmi_epc | output | XLEN | NMI exception PC |

## Verification
The bench puts an RNMI, a regular interrupt and an exception in the same cycle. A design with the priority inverted would vector to the machine trap handler and leave `nmi_epc` stale. It presents several RNMI sources together, including the highest one alone, so a design that picks the top bit or drops the cause's top bit shows a wrong `nmi_cause`. Machine-mode exceptions with the enable bit clear must reach the RNMI exception vector and not `mtvec`. RNMIs held outside instruction boundaries or while masked must not be taken at all. The bench also covers delegation with a mismatched privilege or a cause of XLEN or above, and vectored interrupts against vectored exceptions. These catch designs that delegate from machine mode or add cause×4 for exceptions.

// File: rtl/rnmi_pkg.sv
package rnmi_pkg;

    localparam int CAUSE_W = 8;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    typedef enum logic [1:0] {
        TK_NONE = 2'd0,
        TK_RNMI = 2'd1,
        TK_IRQ  = 2'd2,
        TK_EXC  = 2'd3
    } trap_kind_e;

    typedef struct packed {
        trap_kind_e         kind;
        logic               is_int;
        logic [CAUSE_W-1:0] cause;
    } trap_dec_t;

    // Base with low two bits cleared, plus cause*4 for vectored interrupts.
    function automatic logic [63:0] vec_target(input logic [63:0] tvec,
                                               input logic is_int,
                                               input logic [CAUSE_W-1:0] cause);
        logic [63:0] base;
        logic [63:0] off;
        base = {tvec[63:2], 2'b00};
        off  = (is_int && tvec[1:0] == 2'b01) ?
               {{(64-CAUSE_W-2){1'b0}}, cause, 2'b00} : 64'd0;
        return base + off;
    endfunction

endpackage

// File: rtl/rnmi_pick.sv
module rnmi_pick #(
    parameter int NSRC = 8,
    parameter int IW   = 3
) (
    input  logic [NSRC-1:0] pend,
    output logic            any,
    output logic [IW-1:0]   idx
);
    always_comb begin
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) idx = IW'(i);
        end
    end

    assign any = |pend;
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import rnmi_pkg::*;
(
    input  logic               nmi_en,
    input  logic               boundary,
    input  logic               rnmi_any,
    input  logic [CAUSE_W-1:0] rnmi_cause,
    input  logic               irq_req,
    input  logic [CAUSE_W-1:0] irq_cause,
    input  logic               exc_req,
    input  logic [CAUSE_W-1:0] exc_cause,
    output trap_dec_t          dec
);
    logic async_ok;
    assign async_ok = nmi_en && boundary;

    always_comb begin
        dec = '{kind: TK_NONE, is_int: 1'b0, cause: '0};
        if (async_ok && rnmi_any) begin
            dec = '{kind: TK_RNMI, is_int: 1'b1, cause: rnmi_cause};
        end else if (async_ok && irq_req) begin
            dec = '{kind: TK_IRQ, is_int: 1'b1, cause: irq_cause};
        end else if (exc_req) begin
            dec = '{kind: TK_EXC, is_int: 1'b0, cause: exc_cause};
        end
    end
endmodule

// File: rtl/trap_target.sv
module trap_target
    import rnmi_pkg::*;
#(
    parameter int          XLEN     = 32,
    parameter logic [63:0] IRQ_VEC  = 64'h1000,
    parameter logic [63:0] EXC_VEC  = 64'h1040
) (
    input  trap_dec_t        dec,
    input  logic             nmi_en,
    input  logic [1:0]       cur_priv,
    input  logic [XLEN-1:0]  deleg,
    input  logic [XLEN-1:0]  mtvec,
    input  logic [XLEN-1:0]  stvec,
    output logic [XLEN-1:0]  tgt_pc,
    output logic [1:0]       tgt_priv
);
    localparam int LW = $clog2(XLEN);

    logic        to_s;
    logic [63:0] s_pc;
    logic [63:0] m_pc;

    assign to_s = (cur_priv == PRIV_U || cur_priv == PRIV_S) &&
                  (int'(dec.cause) < XLEN) && deleg[dec.cause[LW-1:0]];
    assign s_pc = vec_target(64'(stvec), dec.is_int, dec.cause);
    assign m_pc = vec_target(64'(mtvec), dec.is_int, dec.cause);

    always_comb begin
        tgt_pc   = '0;
        tgt_priv = PRIV_M;
        unique case (dec.kind)
            TK_RNMI: tgt_pc = IRQ_VEC[XLEN-1:0];
            TK_IRQ, TK_EXC: begin
                if (to_s) begin
                    tgt_priv = PRIV_S;
                    tgt_pc   = s_pc[XLEN-1:0];
                end else if (dec.kind == TK_EXC && !nmi_en) begin
                    tgt_pc   = EXC_VEC[XLEN-1:0];
                end else begin
                    tgt_pc   = m_pc[XLEN-1:0];
                end
            end
            default: tgt_pc = '0;
        endcase
    end
endmodule

// File: rtl/rnmi_trap_ctrl.sv
module rnmi_trap_ctrl
    import rnmi_pkg::*;
#(
    parameter int          XLEN         = 32,
    parameter int          NSRC         = 8,
    parameter logic [63:0] RNMI_IRQ_VEC = 64'h0000_1000,
    parameter logic [63:0] RNMI_EXC_VEC = 64'h0000_1040
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               boundary,
    input  logic [NSRC-1:0]    rnmi_pend,
    input  logic               irq_req,
    input  logic [7:0]         irq_cause,
    input  logic               exc_req,
    input  logic [7:0]         exc_cause,
    input  logic [1:0]         cur_priv,
    input  logic               cur_virt,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [XLEN-1:0]    deleg,
    input  logic [XLEN-1:0]    mtvec,
    input  logic [XLEN-1:0]    stvec,
    input  logic               nmi_ret,
    output logic               trap_taken,
    output logic [XLEN-1:0]    next_pc,
    output logic [1:0]         next_priv,
    output logic               nmi_en,
    output logic [1:0]         nmi_prev_priv,
    output logic               nmi_prev_virt,
    output logic [XLEN-1:0]    nmi_cause,
    output logic [XLEN-1:0]    nmi_epc
);
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic            rnmi_any;
    logic [IW-1:0]   rnmi_idx;
    trap_dec_t       dec;
    logic [XLEN-1:0] tgt_pc;
    logic [1:0]      tgt_priv;

    rnmi_pick #(.NSRC(NSRC), .IW(IW)) u_pick (
        .pend (rnmi_pend),
        .any  (rnmi_any),
        .idx  (rnmi_idx)
    );

    trap_arbiter u_arb (
        .nmi_en     (nmi_en),
        .boundary   (boundary),
        .rnmi_any   (rnmi_any),
        .rnmi_cause (CAUSE_W'(rnmi_idx)),
        .irq_req    (irq_req),
        .irq_cause  (irq_cause),
        .exc_req    (exc_req),
        .exc_cause  (exc_cause),
        .dec        (dec)
    );

    trap_target #(.XLEN(XLEN), .IRQ_VEC(RNMI_IRQ_VEC), .EXC_VEC(RNMI_EXC_VEC)) u_tgt (
        .dec      (dec),
        .nmi_en   (nmi_en),
        .cur_priv (cur_priv),
        .deleg    (deleg),
        .mtvec    (mtvec),
        .stvec    (stvec),
        .tgt_pc   (tgt_pc),
        .tgt_priv (tgt_priv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_taken    <= 1'b0;
            next_pc       <= '0;
            next_priv     <= PRIV_M;
            nmi_en        <= 1'b0;
            nmi_prev_priv <= PRIV_U;
            nmi_prev_virt <= 1'b0;
            nmi_cause     <= '0;
            nmi_epc       <= '0;
        end else begin
            trap_taken <= (dec.kind != TK_NONE);
            if (dec.kind != TK_NONE) begin
                next_pc   <= tgt_pc;
                next_priv <= tgt_priv;
            end
            if (dec.kind == TK_RNMI) begin
                nmi_en        <= 1'b0;
                nmi_prev_priv <= cur_priv;
                nmi_prev_virt <= cur_virt;
                nmi_epc       <= cur_pc;
                nmi_cause     <= {1'b1, (XLEN-1)'(rnmi_idx)};
            end else if (nmi_ret) begin
                nmi_en <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rnmi_trap_chk.sv
module rnmi_trap_chk #(
    parameter int          XLEN    = 32,
    parameter int          NSRC    = 8,
    parameter logic [63:0] IRQ_VEC = 64'h1000,
    parameter logic [63:0] EXC_VEC = 64'h1040
) (
    input logic            clk,
    input logic            rst,
    input logic            boundary,
    input logic [NSRC-1:0] rnmi_pend,
    input logic            irq_req,
    input logic            exc_req,
    input logic [1:0]      cur_priv,
    input logic [XLEN-1:0] cur_pc,
    input logic            trap_taken,
    input logic [XLEN-1:0] next_pc,
    input logic [1:0]      next_priv,
    input logic            nmi_en,
    input logic [XLEN-1:0] nmi_cause,
    input logic [XLEN-1:0] nmi_epc
);
    assert_masked_no_async_R2: assert property (@(posedge clk) disable iff (rst)
        (!nmi_en && !exc_req) |=> !trap_taken);

    assert_rnmi_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (nmi_en && boundary && (|rnmi_pend)) |=>
        (trap_taken && !nmi_en && next_priv == 2'd3 &&
         next_pc == IRQ_VEC[XLEN-1:0] && nmi_epc == $past(cur_pc)));

    assert_rnmi_cause_msb_R4: assert property (@(posedge clk) disable iff (rst)
        (nmi_en && boundary && (|rnmi_pend)) |=> nmi_cause[XLEN-1]);

    assert_exc_vector_R7: assert property (@(posedge clk) disable iff (rst)
        (!nmi_en && exc_req && cur_priv == 2'd3) |=>
        (trap_taken && next_pc == EXC_VEC[XLEN-1:0]));

    assert_boundary_only_R9: assert property (@(posedge clk) disable iff (rst)
        (!boundary && !exc_req) |=> !trap_taken);

    assert_regular_keeps_state_R12: assert property (@(posedge clk) disable iff (rst)
        ((exc_req || irq_req) && !(nmi_en && boundary && (|rnmi_pend))) |=>
        ($stable(nmi_epc) && $stable(nmi_cause)));
endmodule

bind rnmi_trap_ctrl rnmi_trap_chk #(
    .XLEN(XLEN), .NSRC(NSRC), .IRQ_VEC(RNMI_IRQ_VEC), .EXC_VEC(RNMI_EXC_VEC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .boundary   (boundary),
    .rnmi_pend  (rnmi_pend),
    .irq_req    (irq_req),
    .exc_req    (exc_req),
    .cur_priv   (cur_priv),
    .cur_pc     (cur_pc),
    .trap_taken (trap_taken),
    .next_pc    (next_pc),
    .next_priv  (next_priv),
    .nmi_en     (nmi_en),
    .nmi_cause  (nmi_cause),
    .nmi_epc    (nmi_epc)
);

// File: tb/tb_rnmi_trap_ctrl.sv
module tb_rnmi_trap_ctrl;
    localparam int XLEN = 32;
    localparam int NSRC = 8;
    localparam logic [31:0] IRQV = 32'h0000_1000;
    localparam logic [31:0] EXCV = 32'h0000_1040;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic boundary = 0, irq_req = 0, exc_req = 0, cur_virt = 0, nmi_ret = 0;
    logic [NSRC-1:0] rnmi_pend = '0;
    logic [7:0] irq_cause = 0, exc_cause = 0;
    logic [1:0] cur_priv = 2'd3;
    logic [XLEN-1:0] cur_pc = 0, deleg = 0, mtvec = 0, stvec = 0;
    logic trap_taken, nmi_en, nmi_prev_virt;
    logic [XLEN-1:0] next_pc, nmi_cause, nmi_epc;
    logic [1:0] next_priv, nmi_prev_priv;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model state
    logic m_en = 0, m_pv = 0, m_taken = 0;
    logic [1:0] m_pp = 0, m_priv = 2'd3;
    logic [XLEN-1:0] m_cause = 0, m_epc = 0, m_pc = 0;

    always #4 clk = ~clk;

    rnmi_trap_ctrl #(.XLEN(XLEN), .NSRC(NSRC),
                     .RNMI_IRQ_VEC(64'(IRQV)), .RNMI_EXC_VEC(64'(EXCV))) dut (
        .clk(clk), .rst(rst), .boundary(boundary), .rnmi_pend(rnmi_pend),
        .irq_req(irq_req), .irq_cause(irq_cause), .exc_req(exc_req),
        .exc_cause(exc_cause), .cur_priv(cur_priv), .cur_virt(cur_virt),
        .cur_pc(cur_pc), .deleg(deleg), .mtvec(mtvec), .stvec(stvec),
        .nmi_ret(nmi_ret), .trap_taken(trap_taken), .next_pc(next_pc),
        .next_priv(next_priv), .nmi_en(nmi_en), .nmi_prev_priv(nmi_prev_priv),
        .nmi_prev_virt(nmi_prev_virt), .nmi_cause(nmi_cause), .nmi_epc(nmi_epc)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] vtgt(input logic [31:0] tv, input bit isint, input int c);
        logic [31:0] b;
        b = tv & ~32'd3;
        if (isint && tv[1:0] == 2'd1) b = b + 32'(c * 4);
        return b;
    endfunction

    task automatic idle();
        boundary = 0; rnmi_pend = '0; irq_req = 0; exc_req = 0; nmi_ret = 0;
    endtask

    // Compute expectation, advance one edge, compare.
    task automatic step();
        bit tr, ti, te, tos, isint, old_en;
        int c, idx;
        string tt, tp;
        old_en = m_en;
        tr = m_en && boundary && (rnmi_pend != 0);
        ti = m_en && boundary && irq_req && !tr;
        te = exc_req && !tr && !ti;
        tt = "R10"; tp = "R8";
        if (!boundary && rnmi_pend != 0) tt = "R9";
        else if (!m_en && (rnmi_pend != 0 || irq_req)) tt = "R2";
        m_taken = tr || ti || te;
        if (tr) begin
            idx = 0;
            for (int i = NSRC - 1; i >= 0; i--) if (rnmi_pend[i]) idx = i;
            m_pc = IRQV; m_priv = 2'd3;
            m_epc = cur_pc; m_pp = cur_priv; m_pv = cur_virt; m_en = 0;
            m_cause = 32'h8000_0000 | 32'(idx);
            tp = (irq_req || exc_req) ? "R3" : "R5";
        end else if (ti || te) begin
            c = ti ? int'(irq_cause) : int'(exc_cause);
            isint = ti;
            tos = (cur_priv <= 2'd1) && (c < XLEN) && deleg[c % XLEN];
            if (tos) begin
                m_priv = 2'd1; m_pc = vtgt(stvec, isint, c); tp = "R6";
            end else begin
                m_priv = 2'd3;
                if (te && !old_en) begin m_pc = EXCV; tp = "R7"; end
                else m_pc = vtgt(mtvec, isint, c);
            end
            if (ti && exc_req) tp = "R3";
        end
        if (!tr && nmi_ret) m_en = 1;
        @(posedge clk); #1;
        chk(tt, trap_taken, m_taken);
        chk(tp, next_pc, m_pc);
        chk(tp, next_priv, m_priv);
        chk(nmi_ret ? "R11" : (tr ? "R5" : "R12"), nmi_en, m_en);
        chk("R4", nmi_cause, m_cause);
        chk(tr ? "R5" : "R12", nmi_epc, m_epc);
        chk(tr ? "R5" : "R12", {nmi_prev_virt, nmi_prev_priv}, {m_pv, m_pp});
        idle();
    endtask

    initial begin
        #1600000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle();
        mtvec = 32'h0000_2000; stvec = 32'h0000_3000;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1 reset state
        chk("R1", trap_taken, 0); chk("R1", nmi_en, 0); chk("R1", next_priv, 3);
        chk("R1", nmi_cause, 0); chk("R1", nmi_epc, 0); chk("R1", next_pc, 0);
        // R2: masked RNMI and interrupt
        boundary = 1; rnmi_pend = 8'h03; irq_req = 1; irq_cause = 3; step();
        // R11: re-enable
        nmi_ret = 1; step();
        // R3/R4/R5: all three together, sources 5 and 6
        boundary = 1; rnmi_pend = 8'b0110_0000; irq_req = 1; irq_cause = 7;
        exc_req = 1; exc_cause = 2; cur_priv = 2'd0; cur_virt = 1;
        cur_pc = 32'hABCD_0010; step();
        // R7: machine exception while masked
        cur_priv = 2'd3; exc_req = 1; exc_cause = 4; step();
        // R10: idle cycle after trap
        step();
        // R6: delegated vectored interrupt
        nmi_ret = 1; step();
        cur_priv = 2'd1; deleg = 32'h0000_0020; stvec = 32'h0000_3001;
        boundary = 1; irq_req = 1; irq_cause = 5; step();
        // R6: machine mode ignores delegation
        cur_priv = 2'd3; boundary = 1; irq_req = 1; irq_cause = 5; step();
        // R6: cause >= XLEN is never delegated
        cur_priv = 2'd0; deleg = 32'hFFFF_FFFF; exc_req = 1; exc_cause = 8'd40; step();
        // R9: RNMI held off outside a boundary, exception proceeds
        cur_priv = 2'd3; rnmi_pend = 8'h01; exc_req = 1; exc_cause = 1; step();
        // R8: vectored interrupt vs vectored exception in machine mode
        mtvec = 32'h0000_2001;
        boundary = 1; irq_req = 1; irq_cause = 7; step();
        exc_req = 1; exc_cause = 7; step();
        // R4: top source alone
        boundary = 1; rnmi_pend = 8'h80; cur_pc = 32'h0000_5554; step();
        // random phase
        void'($urandom(32'd12345));
        for (int n = 0; n < 3000; n++) begin
            boundary  = ($urandom % 2) == 0;
            rnmi_pend = (($urandom % 7) == 0) ? NSRC'($urandom) : '0;
            irq_req   = ($urandom % 4) == 0;
            irq_cause = 8'($urandom % 40);
            exc_req   = ($urandom % 4) == 0;
            exc_cause = 8'($urandom % 40);
            nmi_ret   = ($urandom % 6) == 0;
            case ($urandom % 3)
                0: cur_priv = 2'd0;
                1: cur_priv = 2'd1;
                default: cur_priv = 2'd3;
            endcase
            cur_virt = 1'($urandom);
            cur_pc   = $urandom & ~32'd3;
            deleg    = $urandom;
            mtvec    = $urandom;
            stvec    = $urandom;
            step();
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule